// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block is a register-driven I2C master sequencer. Software drives it through a small word-addressed register bus. It asks for a bus condition (START, repeated START or STOP) through a control word, or it writes one byte to a data register. The engine then moves the open-drain clock and data lines through the matching sequence and samples the acknowledge bit that the addressed device returns. Every step of the sequence takes one quarter of the SCL period, and that quarter is a fixed number of system clocks set by a parameter.

A sticky status word reports each finished operation and any negative acknowledge. Software clears its bits by writing ones to them. The control word also shows whether the most recent byte went unacknowledged. A pad control bit, which is active-low, can release both bus lines at any moment. The engine also senses SCL: while it has released SCL and a device still holds the line low, the engine waits.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset the control word (bus_addr 0) reads 0, the status word (bus_addr 1) reads 0, the data register (bus_addr 2) reads 0, the pad word (bus_addr 3) reads 0x4, and both bus lines are released.
- R2: The control word holds the enable in bit 0 and the command in bits 2:1 (0 = none, 1 = start or repeated start, 2 = stop; 3 acts as none). A write with enable 1, command 1 and bit 3 at 0 produces a START: SDA falls while SCL is high. It lasts 3 quarter periods and ends with both lines low.
- R3: The same write with bit 3 at 1 produces a repeated START. SDA is released, SCL is released, then SDA falls while SCL is high and SCL is pulled low. It lasts 4 quarter periods and ends with both lines low.
- R4: Command 2 produces a STOP. SDA is held low, SCL is released, and SDA is released while SCL is high. It lasts 3 quarter periods and ends with both lines released.
- R5: A write to the data register, with the stored enable at 1, shifts the low byte out MSB first. It then releases SDA for a ninth, acknowledge clock. SDA changes only while SCL is low. The transfer lasts 36 quarter periods and ends with SCL low and SDA released.
- R6: SDA is sampled high on the acknowledge clock to mean a NAK. After each byte, control bit 3 reads that NAK value, and a NAK also sets status bit 0.
- R7: Status bit 7 reads 1 for exactly the length of an operation. Status bit 3 is set when any operation completes.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Bits in mask 0xFFFFFF60 always read 0.
- R9: A command or data write that arrives while status bit 7 is 1 has no effect on the bus or on the running operation. It sets status bit 2.
- R10: A command write whose bit 0 is 0, or a data write while the stored enable is 0, starts nothing and sets no status bit.
- R11: Pad word bit 2 set to 1 releases both lines at once, whatever the engine state. Set back to 0, it lets the engine drive them again.
- R12: While the engine has released SCL but the SCL line reads low, the quarter timer stops. Each stalled cycle lengthens the operation by one cycle.
- R13: If a completion and a write clearing status bit 3 fall in the same cycle, status bit 3 reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 2 | Word select: 0 control, 1 status, 2 data, 3 pad |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word, combinational |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two things can land in the same cycle: the engine setting the session-done bit at the end of an operation, and software clearing that same bit with a write-one. The bench provokes this by issuing a START and then holding a clear write to the status word on every cycle until the busy bit drops. The done bit then survives only if the set wins, and the bench reads it in the cycle that busy falls. A second overlap places a STOP command inside a running byte transfer. The bench judges it by the unchanged transfer length, the lines staying in their end-of-byte state, and the error bit.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int QTR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_pull,
  output logic        sda_pull
);

  localparam int TW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [TW-1:0] TMAX = TW'(QTR_CYCLES - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_PAD = 2'd3;
  localparam logic [1:0] OP_START = 2'd0, OP_RSTART = 2'd1, OP_STOP = 2'd2, OP_BYTE = 2'd3;
  localparam logic [5:0] ACK_HIGH = 6'd33;

  function automatic logic [1:0] line_lvl(input logic [1:0] op, input logic [5:0] st,
                                          input logic [7:0] tx);
    logic [1:0] q;
    logic [3:0] b;
    q = st[1:0];
    b = st[5:2];
    case (op)
      OP_START:  line_lvl = (st == 6'd0) ? 2'b11 : (st == 6'd1) ? 2'b10 : 2'b00;
      OP_RSTART: line_lvl = (st == 6'd0) ? 2'b01 : (st == 6'd1) ? 2'b11 :
                            (st == 6'd2) ? 2'b10 : 2'b00;
      OP_STOP:   line_lvl = (st == 6'd0) ? 2'b00 : (st == 6'd1) ? 2'b10 : 2'b11;
      default:   line_lvl = {(q == 2'd1) || (q == 2'd2), b[3] ? 1'b1 : tx[~b[2:0]]};
    endcase
  endfunction

  function automatic logic [5:0] last_step(input logic [1:0] op);
    case (op)
      OP_START:  last_step = 6'd2;
      OP_RSTART: last_step = 6'd3;
      OP_STOP:   last_step = 6'd2;
      default:   last_step = 6'd35;
    endcase
  endfunction

  logic          en_q, nak_last_q, nak_smp_q, pad_off_q;
  logic [1:0]    cmd_q, op_q;
  logic          st_done, st_err, st_nak;
  logic [7:0]    tx_q;
  logic          run_q, scl_q, sda_q;
  logic [5:0]    step_q;
  logic [TW-1:0] tmr_q;
  logic [23:0]   unused_hi;

  logic wr_en, ctrl_go, data_go, accept, reject, stall, tick, fin;
  logic [1:0] new_op, nxt_lvl;
  logic [7:0] new_tx, clr;

  assign unused_hi = bus_wdata[31:8];
  assign wr_en   = bus_sel & bus_we;
  assign ctrl_go = wr_en && bus_addr == A_CTRL && bus_wdata[0] &&
                   (bus_wdata[2:1] == 2'd1 || bus_wdata[2:1] == 2'd2);
  assign data_go = wr_en && bus_addr == A_DATA && en_q;
  assign accept  = (ctrl_go | data_go) & ~run_q;
  assign reject  = (ctrl_go | data_go) & run_q;
  assign new_op  = data_go ? OP_BYTE : (bus_wdata[2:1] == 2'd2) ? OP_STOP :
                   bus_wdata[3] ? OP_RSTART : OP_START;
  assign new_tx  = data_go ? bus_wdata[7:0] : tx_q;
  assign stall   = scl_q & ~scl_in;
  assign tick    = run_q & ~stall & (tmr_q == TMAX);
  assign fin     = tick & (step_q == last_step(op_q));
  assign nxt_lvl = line_lvl(op_q, step_q + 6'd1, tx_q);
  assign clr     = (wr_en && bus_addr == A_STAT) ? bus_wdata[7:0] : 8'd0;

  assign scl_pull = ~pad_off_q & ~scl_q;
  assign sda_pull = ~pad_off_q & ~sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      op_q   <= OP_START;
      step_q <= '0;
      tmr_q  <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      tx_q   <= '0;
    end else if (accept) begin
      run_q          <= 1'b1;
      op_q           <= new_op;
      step_q         <= '0;
      tmr_q          <= '0;
      {scl_q, sda_q} <= line_lvl(new_op, 6'd0, new_tx);
      tx_q           <= new_tx;
    end else if (run_q && !stall) begin
      if (tmr_q == TMAX) begin
        tmr_q <= '0;
        if (fin) begin
          run_q <= 1'b0;
        end else begin
          step_q         <= step_q + 6'd1;
          {scl_q, sda_q} <= nxt_lvl;
        end
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nak_smp_q  <= 1'b0;
      nak_last_q <= 1'b0;
    end else begin
      if (tick && op_q == OP_BYTE && step_q == ACK_HIGH) nak_smp_q <= sda_in;
      if (fin && op_q == OP_BYTE) nak_last_q <= nak_smp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      cmd_q     <= 2'd0;
      pad_off_q <= 1'b1;
    end else if (wr_en) begin
      if (bus_addr == A_CTRL) begin
        en_q  <= bus_wdata[0];
        cmd_q <= bus_wdata[2:1];
      end
      if (bus_addr == A_PAD) pad_off_q <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0;
      st_err  <= 1'b0;
      st_nak  <= 1'b0;
    end else begin
      st_done <= fin ? 1'b1 : (st_done & ~clr[3]);
      st_err  <= reject ? 1'b1 : (st_err & ~clr[2]);
      st_nak  <= (fin && op_q == OP_BYTE && nak_smp_q) ? 1'b1 : (st_nak & ~clr[0]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[3:0] = {nak_last_q, cmd_q, en_q};
      A_STAT:  bus_rdata[7:0] = {run_q, 3'b000, st_done, st_err, 1'b0, st_nak};
      A_DATA:  bus_rdata[7:0] = tx_q;
      default: bus_rdata[2]   = pad_off_q;
    endcase
  end

endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [2:0] wd,
  input logic       scl_in,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       run,
  input logic       scl_q,
  input logic       sda_q,
  input logic       st_done,
  input logic [1:0] op,
  input logic [5:0] step
);

  AST_PAD_RELEASES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd3 && wd[2]) |=> (!scl_pull && !sda_pull)); // R11

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> st_done); // R7

  AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bus_sel && bus_we && (bus_addr == 2'd0 || bus_addr == 2'd2)) |=> $stable(op)); // R9

  AST_DISABLED_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && bus_sel && bus_we && bus_addr == 2'd0 && !wd[0]) |=> !run); // R10

  AST_STOP_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && op == 2'd2) |-> (scl_q && sda_q)); // R4

  AST_BYTE_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 2'd3 && $past(run) && $past(scl_q) && scl_q) |-> $stable(sda_q)); // R5

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && scl_q && !scl_in) |=> (run && $stable(step))); // R12

endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .wd(bus_wdata[2:0]), .scl_in(scl_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .run(run_q), .scl_q(scl_q), .sda_q(sda_q), .st_done(st_done), .op(op_q), .step(step_q)
);

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  localparam int Q = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_pull, sda_pull;
  logic        stretch = 1'b0, ack_drv = 1'b0, ack_en = 1'b1;
  logic        scl_line, sda_line;

  always #2 clk = ~clk;

  assign scl_line = ~(scl_pull | stretch);
  assign sda_line = ~(sda_pull | ack_drv);

  i2c_cmd_engine #(.QTR_CYCLES(Q)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  int n_chk = 0, n_bad = 0;

  // simple bus device: counts clocks, captures bits, answers the ninth clock
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         bitcnt = 0, n_start = 0, n_stop = 0;
  logic [7:0] rx = 8'd0;

  always @(negedge clk) begin
    if (scl_line && !p_scl) begin
      if (bitcnt < 8) rx = {rx[6:0], sda_line};
      bitcnt++;
    end else if (!scl_line && p_scl) begin
      if (bitcnt == 8) ack_drv = ack_en;
      else if (bitcnt == 9) begin
        ack_drv = 1'b0;
        bitcnt  = 0;
      end
    end
    if (scl_line && p_scl && !sda_line && p_sda) begin n_start++; bitcnt = 0; end
    if (scl_line && p_scl && sda_line && !p_sda) begin n_stop++;  bitcnt = 0; end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  typedef struct packed {
    logic [1:0] kind;   // 0 start, 1 restart, 2 stop, 3 byte
    logic [7:0] dat;
    logic       ack;
    logic [7:0] cyc;
    logic       nak;
    logic       scl_e;
    logic       sda_e;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 8'h00, 1'b1, 8'(3*Q),  1'b0, 1'b0, 1'b0},
    '{2'd3, 8'hA5, 1'b1, 8'(36*Q), 1'b0, 1'b0, 1'b1},
    '{2'd3, 8'h3C, 1'b0, 8'(36*Q), 1'b1, 1'b0, 1'b1},
    '{2'd1, 8'h00, 1'b1, 8'(4*Q),  1'b0, 1'b0, 1'b0},
    '{2'd3, 8'hFF, 1'b1, 8'(36*Q), 1'b0, 1'b0, 1'b1},
    '{2'd3, 8'h00, 1'b1, 8'(36*Q), 1'b0, 1'b0, 1'b1},
    '{2'd2, 8'h00, 1'b1, 8'(3*Q),  1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n, input int rel);
    logic [31:0] s;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (n == rel) stretch = 1'b0;
      rd(2'd1, s);
      if (!s[7]) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, s0, p0;
    string tg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, r); chk("R1 control", r, 32'h0);
    rd(2'd1, r); chk("R1 status", r, 32'h0);
    rd(2'd2, r); chk("R1 data", r, 32'h0);
    rd(2'd3, r); chk("R11 pad reset", r, 32'h4);
    chk("R1 lines", {30'd0, scl_line, sda_line}, 32'h3);

    wr(2'd3, 32'h0);
    wr(2'd0, 32'h1);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      v = VECS[i];
      ack_en = v.ack;
      s0 = n_start;
      p0 = n_stop;
      tg = (v.kind == 2'd0) ? "R2" : (v.kind == 2'd1) ? "R3" : (v.kind == 2'd2) ? "R4" : "R5";
      if (v.kind == 2'd3) wr(2'd2, {24'd0, v.dat});
      else wr(2'd0, (v.kind == 2'd2) ? 32'h5 : (v.kind == 2'd1) ? 32'hB : 32'h3);
      wait_idle(n, -1);
      chk({tg, " R7 duration"}, n, {24'd0, v.cyc});
      rd(2'd1, r);
      chk("R7 done", {31'd0, r[3]}, 32'h1);
      chk("R6 status nak", {31'd0, r[0]}, {31'd0, v.nak});
      chk("R8 reserved", r & 32'hFFFFFF60, 32'h0);
      chk({tg, " end lines"}, {30'd0, scl_line, sda_line}, {30'd0, v.scl_e, v.sda_e});
      if (v.kind == 2'd3) begin
        chk("R5 bits", {24'd0, rx}, {24'd0, v.dat});
        rd(2'd0, r);
        chk("R6 control nak", {31'd0, r[3]}, {31'd0, v.nak});
      end
      if (v.kind == 2'd0 || v.kind == 2'd1) chk({tg, " start cond"}, n_start - s0, 1);
      if (v.kind == 2'd2) chk("R4 stop cond", n_stop - p0, 1);
      wr(2'd0, 32'h1);
      wr(2'd1, 32'hFF);
    end

    // R9: stop request inside a running byte is dropped
    wr(2'd0, 32'h3);
    wait_idle(n, -1);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'hFF);
    ack_en = 1'b1;
    p0 = n_stop;
    wr(2'd2, 32'h96);
    wr(2'd0, 32'h5);
    wait_idle(n, -1);
    chk("R9 duration", n, 36*Q - 2);
    chk("R9 byte intact", {24'd0, rx}, 32'h96);
    chk("R9 lines", {30'd0, scl_line, sda_line}, 32'h1);
    chk("R9 no stop", n_stop - p0, 0);
    rd(2'd1, r);
    chk("R9 error bit", {31'd0, r[2]}, 32'h1);

    // R8: write-one-to-clear
    wr(2'd1, 32'h0);
    rd(2'd1, r); chk("R8 zero write", r, 32'h0C);
    wr(2'd1, 32'h4);
    rd(2'd1, r); chk("R8 clear error", r, 32'h08);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, r); chk("R8 clear all", r, 32'h0);
    wr(2'd0, 32'h1);

    // R10: disabled requests
    wr(2'd0, 32'h4);
    rd(2'd1, r); chk("R10 command ignored", r, 32'h0);
    chk("R10 lines", {30'd0, scl_line, sda_line}, 32'h1);
    wr(2'd2, 32'h55);
    rd(2'd1, r); chk("R10 data ignored", r, 32'h0);
    rd(2'd2, r); chk("R10 data kept", r, 32'h96);
    chk("R10 lines after data", {30'd0, scl_line, sda_line}, 32'h1);
    wr(2'd0, 32'h1);

    // R11: pad release
    wr(2'd3, 32'h4);
    chk("R11 released", {30'd0, scl_line, sda_line}, 32'h3);
    rd(2'd3, r); chk("R11 readback", r, 32'h4);
    wr(2'd3, 32'h0);
    chk("R11 driven again", {30'd0, scl_line, sda_line}, 32'h1);

    // R12: SCL held low by a device during a stop
    stretch = 1'b1;
    p0 = n_stop;
    wr(2'd0, 32'h5);
    wait_idle(n, 10);
    chk("R12 stretched duration", n, 2*Q + 10);
    chk("R12 lines", {30'd0, scl_line, sda_line}, 32'h3);
    chk("R4 stop after stretch", n_stop - p0, 1);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'hFF);

    // R13: completion and clear in the same cycle
    wr(2'd0, 32'h3);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h8;
    for (int i = 0; i < 200; i++) begin
      #1;
      if (!bus_rdata[7]) break;
      @(negedge clk);
    end
    chk("R13 set wins", {31'd0, bus_rdata[3]}, 32'h1);
    bus_sel = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    rd(2'd1, r); chk("R13 done held", {31'd0, r[3]}, 32'h1);

    summary();
    $finish;
  end
endmodule